// File: doc/BRIEF.md
# Dual-Slope Phase-Correct PWM Timer

This block is a 16-bit up/down timer that produces symmetric, centre-aligned pulse-width-modulated waveforms. On every enabled timer tick the counter steps by one. It climbs from zero to a ceiling value (TOP), stays at TOP for a single tick, and then falls back to zero. Because it reverses at both ends, each pulse is centred in the period. A mode field picks the ceiling. It can be one of three fixed resolutions, or it can come from one of two programmable registers: a dedicated ceiling register or the channel A compare register.

Two compare channels, A and B, drive one output pin each. Each pin can be off, non-inverted or inverted. Software writes go through a small register write port. Compare and ceiling writes land in shadow buffers, and those buffers are copied into the active registers when the counter reaches TOP, so a period is never cut in half. Four sticky event flags report the compare matches, reaching the ceiling and reaching zero. Each flag is cleared by writing a 1 to it. The ceiling must be at least 3; smaller ceilings are not supported.

Top module: `dspwm_timer`

## Requirements
- R1: While running, the counter changes only on a cycle with `tick` high. It steps 0,1,…,TOP,TOP-1,…,1,0,1,… so it shows TOP for exactly one tick and zero for exactly one tick per period.
- R2: The mode is `ctrl[3:0]` (write address 0). Mode 1 gives TOP = 0x00FF, mode 2 gives 0x01FF, mode 3 gives 0x03FF, mode 10 uses the active ceiling register and mode 11 uses the active channel A compare register.
- R3: In any other mode the counter holds its value, and every active register follows its shadow buffer on every cycle.
- R4: In a running mode, a write to the compare A buffer (address 1), the compare B buffer (address 2) or the ceiling buffer (address 3) takes effect only at the tick on which the counter equals TOP.
- R5: In modes 1, 2 and 3, a compare write is masked at write time to 8, 9 or 10 bits respectively.
- R6: Flag bit 0 is set by a tick on which the counter is zero.
- R7: Flag bit 1 (channel A) or bit 2 (channel B) is set by a tick on which the counter equals that channel's active compare value. A compare value above TOP never matches, so its pin never changes.
- R8: At the TOP tick, mode 10 sets flag bit 3 and mode 11 sets flag bit 1.
- R9: The output mode is `ctrl[5:4]` for A and `ctrl[7:6]` for B. In mode 2 the pin clears on a match while counting up and sets on a match while counting down. Mode 3 does the opposite. Modes 0 and 1 hold the pin low.
- R10: Writing address 4 clears each flag whose data bit is 1. A flag that is set in the same cycle stays set.
- R11: After reset the counter, the pins, the flags and all registers are zero, and the counting direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timer enable; the counter advances on cycles where it is high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | 0 control, 1 compare A, 2 compare B, 3 ceiling, 4 flag clear |
| wr_data | input | 16 | Write data |
| count | output | 16 | Current counter value |
| pwm_a | output | 1 | Channel A waveform |
| pwm_b | output | 1 | Channel B waveform |
| flags | output | 4 | {ceiling, compare B, compare A, bottom} event flags |

## Verification
The assertions check, on every cycle, that the counter moves by exactly one on each running tick, that it stays put without a tick or in a stopped mode, and that it turns downward after TOP. They also check that the active compare value changes only at TOP, that a disabled pin stays low, and that the bottom and ceiling flags follow their events. Other behaviours depend on a sequence of writes over several periods, so only the bench's scenarios can show them. These are masking at write time, a deferred ceiling change that shortens the next period, compare values above TOP that never match, and the pin polarity in both slope directions. The bench runs a requirement-level model alongside the design and compares the count, the pins and the flags after every step.

// File: rtl/dspwm_timer.sv
module dspwm_timer #(
  parameter int W  = 16,
  parameter int MW = 4,
  parameter int AW = 3,
  parameter int FW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [W-1:0]  wr_data,
  output logic [W-1:0]  count,
  output logic          pwm_a,
  output logic          pwm_b,
  output logic [FW-1:0] flags
);
  localparam logic [MW-1:0] M_FIX8  = MW'(1);
  localparam logic [MW-1:0] M_FIX9  = MW'(2);
  localparam logic [MW-1:0] M_FIX10 = MW'(3);
  localparam logic [MW-1:0] M_CEIL  = MW'(10);
  localparam logic [MW-1:0] M_CMPA  = MW'(11);
  localparam logic [AW-1:0] A_CTRL = AW'(0);
  localparam logic [AW-1:0] A_CMPA = AW'(1);
  localparam logic [AW-1:0] A_CMPB = AW'(2);
  localparam logic [AW-1:0] A_CEIL = AW'(3);
  localparam logic [AW-1:0] A_FCLR = AW'(4);

  logic [MW-1:0] mode_q;
  logic [1:0]    oma_q, omb_q;
  logic [W-1:0]  buf_a, buf_b, buf_c, act_a, act_b, act_c;
  logic [W-1:0]  cnt_q, top_val, wmask;
  logic          up_q, pa_q, pb_q, run_ok;
  logic [FW-1:0] flg_q, f_set, f_clr;

  always_comb begin
    run_ok  = 1'b1;
    top_val = '0;
    wmask   = '1;
    case (mode_q)
      M_FIX8:  begin top_val = W'(16'h00FF); wmask = W'(16'h00FF); end
      M_FIX9:  begin top_val = W'(16'h01FF); wmask = W'(16'h01FF); end
      M_FIX10: begin top_val = W'(16'h03FF); wmask = W'(16'h03FF); end
      M_CEIL:  top_val = act_c;
      M_CMPA:  top_val = act_a;
      default: run_ok = 1'b0;
    endcase
  end

  wire step    = tick && run_ok;
  wire at_top  = (cnt_q == top_val);
  wire at_bot  = (cnt_q == '0);
  wire hit_a   = (cnt_q == act_a);
  wire hit_b   = (cnt_q == act_b);
  wire do_load = !run_ok || (step && at_top);
  wire wr_ctl  = wr_en && (wr_addr == A_CTRL);

  assign f_set = step ? {at_top && (mode_q == M_CEIL), hit_b,
                         hit_a || (at_top && (mode_q == M_CMPA)), at_bot}
                      : '0;
  assign f_clr = (wr_en && wr_addr == A_FCLR) ? wr_data[FW-1:0] : '0;

  assign count = cnt_q;
  assign pwm_a = oma_q[1] && pa_q;
  assign pwm_b = omb_q[1] && pb_q;
  assign flags = flg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      oma_q  <= '0;
      omb_q  <= '0;
      buf_a  <= '0;
      buf_b  <= '0;
      buf_c  <= '0;
    end else if (wr_en) begin
      if (wr_ctl) begin
        mode_q <= wr_data[MW-1:0];
        oma_q  <= wr_data[MW+1:MW];
        omb_q  <= wr_data[MW+3:MW+2];
      end
      if (wr_addr == A_CMPA) buf_a <= wr_data & wmask;
      if (wr_addr == A_CMPB) buf_b <= wr_data & wmask;
      if (wr_addr == A_CEIL) buf_c <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_a <= '0;
      act_b <= '0;
      act_c <= '0;
    end else if (do_load) begin
      act_a <= buf_a;
      act_b <= buf_b;
      act_c <= buf_c;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      if (up_q) begin
        if (cnt_q >= top_val) begin
          up_q  <= 1'b0;
          cnt_q <= cnt_q - 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end else if (at_bot) begin
        up_q  <= 1'b1;
        cnt_q <= cnt_q + 1'b1;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pa_q  <= 1'b0;
      pb_q  <= 1'b0;
      flg_q <= '0;
    end else begin
      if (step && hit_a && oma_q[1]) pa_q <= up_q ? oma_q[0] : !oma_q[0];
      if (step && hit_b && omb_q[1]) pb_q <= up_q ? omb_q[0] : !omb_q[0];
      flg_q <= (flg_q & ~f_clr) | f_set;
    end
  end
endmodule

module dspwm_timer_chk #(
  parameter int W  = 16,
  parameter int MW = 4,
  parameter int FW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          run_ok,
  input logic          up_q,
  input logic [MW-1:0] mode_q,
  input logic [W-1:0]  cnt_q,
  input logic [W-1:0]  top_val,
  input logic [W-1:0]  act_a,
  input logic [1:0]    oma_q,
  input logic          pwm_a,
  input logic [FW-1:0] flags
);
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(cnt_q));
  assert_unit_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_ok) |=> (cnt_q == W'($past(cnt_q) + 1'b1)) || (cnt_q == W'($past(cnt_q) - 1'b1)));
  assert_turn_at_top_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_ok && up_q && cnt_q == top_val) |=> (!up_q && cnt_q == W'($past(cnt_q) - 1'b1)));
  assert_stopped_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_ok |=> $stable(cnt_q));
  assert_load_at_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (run_ok && !(tick && cnt_q == top_val)) |=> $stable(act_a));
  assert_bottom_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_ok && cnt_q == '0) |=> flags[0]);
  assert_ceiling_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && run_ok && mode_q == MW'(10) && cnt_q == top_val) |=> flags[3]);
  assert_pin_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !oma_q[1] |-> !pwm_a);
endmodule

bind dspwm_timer dspwm_timer_chk #(.W(W), .MW(MW), .FW(FW)) chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .run_ok(run_ok), .up_q(up_q),
  .mode_q(mode_q), .cnt_q(cnt_q), .top_val(top_val), .act_a(act_a),
  .oma_q(oma_q), .pwm_a(pwm_a), .flags(flags)
);

// File: tb/dspwm_timer_tb_top.sv
module dspwm_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [15:0] count;
  logic        pwm_a, pwm_b;
  logic [3:0]  flags;

  int n_run = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [15:0] c;
    logic        a;
    logic        b;
    logic [3:0]  f;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];

  logic [3:0]  m_mode = '0;
  logic [1:0]  m_oa = '0, m_ob = '0;
  logic [15:0] m_ba = '0, m_bb = '0, m_bc = '0;
  logic [15:0] m_aa = '0, m_ab = '0, m_ac = '0;
  logic [15:0] m_cnt = '0;
  logic        m_up = 1'b1, m_pa = 1'b0, m_pb = 1'b0;
  logic [3:0]  m_fl = '0;

  dspwm_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .count(count), .pwm_a(pwm_a), .pwm_b(pwm_b), .flags(flags)
  );

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic we, input logic [2:0] a,
                      input logic [15:0] d, input string tag);
    logic        valid, hit_a, hit_b, at_top;
    logic [15:0] top, msk;
    logic [3:0]  set, clr;
    exp_t        e;
    @(negedge clk);
    tick = tk; wr_en = we; wr_addr = a; wr_data = d;
    valid = 1'b1; top = '0; msk = 16'hFFFF;
    case (m_mode)
      4'd1:  begin top = 16'h00FF; msk = 16'h00FF; end
      4'd2:  begin top = 16'h01FF; msk = 16'h01FF; end
      4'd3:  begin top = 16'h03FF; msk = 16'h03FF; end
      4'd10: top = m_ac;
      4'd11: top = m_aa;
      default: valid = 1'b0;
    endcase
    at_top = (m_cnt == top);
    hit_a  = (m_cnt == m_aa);
    hit_b  = (m_cnt == m_ab);
    set = '0;
    clr = (we && a == 3'd4) ? d[3:0] : 4'h0;
    if (tk && valid) begin
      set = {at_top && m_mode == 4'd10, hit_b, hit_a || (at_top && m_mode == 4'd11), m_cnt == 16'd0};
      if (hit_a && m_oa[1]) m_pa = m_up ? m_oa[0] : !m_oa[0];
      if (hit_b && m_ob[1]) m_pb = m_up ? m_ob[0] : !m_ob[0];
    end
    if (!valid || (tk && at_top)) begin
      m_aa = m_ba; m_ab = m_bb; m_ac = m_bc;
    end
    if (tk && valid) begin
      if (m_up) begin
        if (m_cnt >= top) begin m_up = 1'b0; m_cnt = m_cnt - 16'd1; end
        else m_cnt = m_cnt + 16'd1;
      end else if (m_cnt == 16'd0) begin
        m_up = 1'b1; m_cnt = 16'd1;
      end else m_cnt = m_cnt - 16'd1;
    end
    m_fl = (m_fl & ~clr) | set;
    if (we) begin
      case (a)
        3'd0: begin m_mode = d[3:0]; m_oa = d[5:4]; m_ob = d[7:6]; end
        3'd1: m_ba = d & msk;
        3'd2: m_bb = d & msk;
        3'd3: m_bc = d;
        default: ;
      endcase
    end
    e.c = m_cnt;
    e.a = m_oa[1] && m_pa;
    e.b = m_ob[1] && m_pb;
    e.f = m_fl;
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d, input string tag);
    step(1'b0, 1'b1, a, d, tag);
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 3'd0, 16'd0, tag);
      if (i % 3 == 2) step(1'b0, 1'b0, 3'd0, 16'd0, tag);
    end
  endtask

  initial begin : monitor
    exp_t  e;
    string t;
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check({t, " count"}, 32'(count), 32'(e.c));
        check({t, " pwm_a"}, 32'(pwm_a), 32'(e.a));
        check({t, " pwm_b"}, 32'(pwm_b), 32'(e.b));
        check({t, " flags"}, 32'(flags), 32'(e.f));
      end
    end
  end

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check("R11 reset count", 32'(count), 32'd0);
    check("R11 reset pwm_a", 32'(pwm_a), 32'd0);
    check("R11 reset pwm_b", 32'(pwm_b), 32'd0);
    check("R11 reset flags", 32'(flags), 32'd0);

    wr(3'd1, 16'd6, "R3");
    wr(3'd2, 16'd2, "R3");
    wr(3'd3, 16'd9, "R3");
    run(5, "R3 stopped");
    wr(3'd0, 16'h00EB, "R2 mode11");
    run(40, "R1 dual slope");
    wr(3'd2, 16'd3, "R4");
    wr(3'd1, 16'd8, "R4");
    run(40, "R4 deferred load");
    wr(3'd4, 16'h000F, "R10 clear");
    run(10, "R6 bottom");
    step(1'b1, 1'b1, 3'd4, 16'h000F, "R10 set wins");
    run(12, "R10");
    wr(3'd2, 16'd20, "R7");
    run(40, "R7 above top");
    wr(3'd3, 16'd5, "R8");
    wr(3'd0, 16'h00EA, "R8 mode10");
    run(30, "R8 ceiling flag");
    wr(3'd4, 16'h000F, "R10");
    wr(3'd0, 16'h000A, "R9 pins off");
    run(20, "R9 off");
    wr(3'd0, 16'h007A, "R9 inverted A");
    run(30, "R9 polarity");
    wr(3'd0, 16'h00E1, "R5 mode1");
    wr(3'd1, 16'hFF10, "R5 mask8");
    run(600, "R5 mask8");
    wr(3'd0, 16'h00E3, "R5 mode3");
    wr(3'd2, 16'hFC40, "R5 mask10");
    run(2100, "R5 mask10");
    wr(3'd0, 16'h00E2, "R2 mode2");
    run(100, "R2 fixed 9-bit");
    wr(3'd0, 16'h0000, "R3 stop");
    run(5, "R3 stopped again");
    repeat (4) @(posedge clk);
    #5;
    finish_run();
  end
endmodule